// File: doc/BRIEF.md
# Configuration Cycle Address Encoder

This block turns a configuration-space request into the two values a host bridge needs to reach a target's configuration registers through a 16 MB configuration aperture. The request carries a bus number, a device/function byte and a register byte offset. The block returns an offset inside the aperture and the matching translation-control word that goes into the aperture's map register. The requester hands in one request with a valid/ready handshake. One clock later the block presents a registered result. It holds that result until the consumer takes it.

Requests to bus zero become type 0 cycles. The target device is picked by a single IDSEL line. Lines for low slot numbers fit inside the aperture offset. The lines for higher slots do not fit there, so the block places them in the upper bits of the map word instead. Requests to any other bus become type 1 cycles. For these the map word tells the bridge to drive the two lowest address lines from the host, and the offset carries the bus and device/function fields directly. Any request field wider than a byte is rejected. The result then carries an error flag and repeats the previous offset and map values.

Top module: `cfgaddr_gen`

## Requirements
- R1: A request whose bus number is 0 yields a type 0 result. The map word has bit 0 clear and bits 3:1 equal to 3'b101.
- R2: A request with a nonzero bus number yields a type 1 result. The offset is bus<<16 | devfn<<8 | regoff. The map word is exactly 32'h0000_000B, so bits 3:1 are 3'b101, bit 0 is set and every bit above 3 is clear.
- R3: In a type 0 result, offset bits 10:8 hold the function number (devfn bits 2:0) and offset bits 7:0 hold the register byte offset.
- R4: In a type 0 result with slot (devfn bits 7:3) of 12 or less, offset bit (slot+11) is the only bit set in offset bits 23:11. Map bits 31:4 are all clear.
- R5: In a type 0 result with slot above 12, offset bits 23:11 are all clear. Map bit (slot-5) is the only bit set in map bits 31:4.
- R6: A request with bus, devfn or register offset above 255 produces a result with the error flag set. The offset and map outputs keep the values of the last legal result, or zero if there has been none. A legal result has the error flag clear.
- R7: The block accepts a request only while it holds no result, so req_ready is the inverse of rsp_valid. A result appears on the clock edge after acceptance. The result stays stable until rsp_ready is seen high with rsp_valid.
- R8: While reset is held (synchronous, active-low), rsp_valid, rsp_err, rsp_offset and rsp_map are cleared and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_bus | input | REQ_W (10) | Bus number, legal range 0..255 |
| req_devfn | input | REQ_W (10) | Device/function byte, legal range 0..255 |
| req_regoff | input | REQ_W (10) | Register byte offset, legal range 0..255 |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_offset | output | ADDR_W (24) | Offset inside the configuration aperture |
| rsp_map | output | MAP_W (32) | Map register word for the aperture |
| rsp_err | output | 1 | Result belongs to an illegal request |

## Verification
The properties assume a consumer that eventually raises rsp_ready and a reset that is low at the first clock edge. The encoding properties look only at results that have the error flag clear. They take map bit 0 as the marker of cycle type, which only holds if every legal request reaches the encoder intact. The stimulus covers slots on both sides of the slot-12 boundary, both cycle types, each kind of out-of-range field, and a legal request after an illegal one. It drives rsp_ready in a stalling pattern so that the result-holding rule is exercised.

// File: rtl/cfgaddr_pkg.sv
// Package: cfgaddr_pkg
// Shared constants and types for the configuration address encoder.
// Assumes map word bits 3:1 carry the cycle-kind code and bit 0 selects
// host-driven low address lines.
package cfgaddr_pkg;

    // Code written into map bits 3:1 for configuration cycles (R1, R2)
    localparam logic [2:0] MAP_CFG_CODE = 3'b101;

    // Kind of configuration cycle produced
    typedef enum logic {
        CYC_TYPE0 = 1'b0,
        CYC_TYPE1 = 1'b1
    } cyc_kind_e;

endpackage

// File: rtl/cfgaddr_legal.sv
// Module: cfgaddr_legal
// Flags a request as legal when every input field fits in FIELD_W bits.
// Assumes REQ_W > FIELD_W; one identical range check is generated per field.
module cfgaddr_legal #(
    parameter int REQ_W   = 10,
    parameter int FIELD_W = 8,
    parameter int NFIELD  = 3
) (
    input  logic [NFIELD*REQ_W-1:0] fields,
    output logic                    legal
);

    localparam int HI_W = REQ_W - FIELD_W;

    logic [NFIELD-1:0] fits;

    // One range check per field: upper bits must all be zero (R6)
    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        logic [HI_W-1:0] upper;
        assign upper   = fields[f*REQ_W + FIELD_W +: HI_W];
        assign fits[f] = (upper == '0);
    end

    // Request is legal only when all fields fit
    assign legal = &fits;

endmodule

// File: rtl/cfgaddr_encode.sv
// Module: cfgaddr_encode
// Combinational encoder for configuration offsets and map words.
// Assumes fields are already trimmed to FIELD_W bits. Slots up to
// ADDR_SLOT_MAX select a device through an offset bit; higher slots
// select it through a map bit starting at MAP_DEV_LSB.
module cfgaddr_encode
    import cfgaddr_pkg::*;
#(
    parameter int FIELD_W  = 8,
    parameter int FUNC_W   = 3,
    parameter int ADDR_W   = 24,
    parameter int MAP_W    = 32,
    parameter int DEV_BASE = 11
) (
    input  logic [FIELD_W-1:0] bus,
    input  logic [FIELD_W-1:0] devfn,
    input  logic [FIELD_W-1:0] regoff,
    output logic [ADDR_W-1:0]  offset,
    output logic [MAP_W-1:0]   map_word
);

    localparam int SLOT_W        = FIELD_W - FUNC_W;
    localparam int NUM_SLOTS     = 1 << SLOT_W;
    localparam int ADDR_SLOT_MAX = ADDR_W - 1 - DEV_BASE;
    localparam int MAP_DEV_LSB   = 8;
    localparam int HI_SLOTS      = NUM_SLOTS - ADDR_SLOT_MAX - 1;

    cyc_kind_e              kind;
    logic [SLOT_W-1:0]      slot;
    logic [FUNC_W-1:0]      func;
    logic [NUM_SLOTS-1:0]   slot_hit;
    logic [ADDR_W-1:0]      addr_dev;
    logic [MAP_W-1:0]       map_dev;
    logic [ADDR_W-1:0]      off_t0;
    logic [ADDR_W-1:0]      off_t1;

    // Split the device/function byte into slot and function
    assign slot = devfn[FIELD_W-1:FUNC_W];
    assign func = devfn[FUNC_W-1:0];

    // Bus zero means a type 0 cycle, anything else type 1 (R1, R2)
    assign kind = (bus == '0) ? CYC_TYPE0 : CYC_TYPE1;

    // One-hot slot decode, one comparator per slot
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_hit[s] = (slot == SLOT_W'(s));
    end

    // Low slots land in the offset, high slots in the map word (R4, R5)
    assign addr_dev = ADDR_W'(slot_hit[ADDR_SLOT_MAX:0]) << DEV_BASE;
    assign map_dev  = MAP_W'(slot_hit[NUM_SLOTS-1:ADDR_SLOT_MAX+1]) << MAP_DEV_LSB;

    // Type 0 offset: device line, function and register byte (R3)
    assign off_t0 = addr_dev | (ADDR_W'(func) << FIELD_W) | ADDR_W'(regoff);

    // Type 1 offset: bus, devfn and register bytes side by side (R2)
    assign off_t1 = ADDR_W'({bus, devfn, regoff});

    // Select offset and map word by cycle kind
    always_comb begin
        if (kind == CYC_TYPE0) begin
            offset   = off_t0;
            map_word = map_dev | MAP_W'({MAP_CFG_CODE, 1'b0});
        end else begin
            offset   = off_t1;
            map_word = MAP_W'({MAP_CFG_CODE, 1'b1});
        end
    end

    // Check that the chosen widths can hold every field
    initial begin
        if (ADDR_W < 3 * FIELD_W) $error("ADDR_W too narrow for type 1 offset");
        if (MAP_W < MAP_DEV_LSB + HI_SLOTS) $error("MAP_W too narrow for high slots");
    end

endmodule

// File: rtl/cfgaddr_hold.sv
// Module: cfgaddr_hold
// Output register stage with valid/ready handshake on both sides.
// Assumes one result in flight; a new request is taken only once the
// current result has been accepted.
module cfgaddr_hold #(
    parameter int ADDR_W = 24,
    parameter int MAP_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              legal,
    input  logic [ADDR_W-1:0] next_offset,
    input  logic [MAP_W-1:0]  next_map,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_offset,
    output logic [MAP_W-1:0]  rsp_map,
    output logic              rsp_err
);

    logic take;

    // Ready only when empty (R7)
    assign req_ready = !rsp_valid;
    assign take      = req_valid && req_ready;

    // Register results; illegal requests only raise the flag (R6, R7, R8)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_offset <= '0;
            rsp_map    <= '0;
        end else begin
            if (rsp_valid && rsp_ready) begin
                rsp_valid <= 1'b0;
            end
            if (take) begin
                rsp_valid <= 1'b1;
                rsp_err   <= !legal;
                if (legal) begin
                    rsp_offset <= next_offset;
                    rsp_map    <= next_map;
                end
            end
        end
    end

endmodule

// File: rtl/cfgaddr_gen.sv
// Module: cfgaddr_gen (top)
// Builds configuration aperture offsets and map words from bus, devfn
// and register offset requests, with a registered one-cycle result.
// Assumes REQ_W is wider than a byte so out-of-range values can be seen.
module cfgaddr_gen #(
    parameter int REQ_W    = 10,
    parameter int FIELD_W  = 8,
    parameter int FUNC_W   = 3,
    parameter int ADDR_W   = 24,
    parameter int MAP_W    = 32,
    parameter int DEV_BASE = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [REQ_W-1:0]  req_bus,
    input  logic [REQ_W-1:0]  req_devfn,
    input  logic [REQ_W-1:0]  req_regoff,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_offset,
    output logic [MAP_W-1:0]  rsp_map,
    output logic              rsp_err
);

    localparam int NFIELD = 3;

    logic              legal;
    logic [ADDR_W-1:0] enc_offset;
    logic [MAP_W-1:0]  enc_map;

    // Range check on all three request fields
    cfgaddr_legal #(
        .REQ_W   (REQ_W),
        .FIELD_W (FIELD_W),
        .NFIELD  (NFIELD)
    ) u_legal (
        .fields ({req_bus, req_devfn, req_regoff}),
        .legal  (legal)
    );

    // Encoding of the trimmed fields
    cfgaddr_encode #(
        .FIELD_W  (FIELD_W),
        .FUNC_W   (FUNC_W),
        .ADDR_W   (ADDR_W),
        .MAP_W    (MAP_W),
        .DEV_BASE (DEV_BASE)
    ) u_encode (
        .bus      (req_bus[FIELD_W-1:0]),
        .devfn    (req_devfn[FIELD_W-1:0]),
        .regoff   (req_regoff[FIELD_W-1:0]),
        .offset   (enc_offset),
        .map_word (enc_map)
    );

    // Result register and handshake
    cfgaddr_hold #(
        .ADDR_W (ADDR_W),
        .MAP_W  (MAP_W)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .legal       (legal),
        .next_offset (enc_offset),
        .next_map    (enc_map),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_offset  (rsp_offset),
        .rsp_map     (rsp_map),
        .rsp_err     (rsp_err)
    );

endmodule

// File: rtl/cfgaddr_gen_sva.sv
// Module: cfgaddr_gen_sva
// Port-level property checker bound to cfgaddr_gen.
module cfgaddr_gen_sva #(
    parameter int ADDR_W   = 24,
    parameter int MAP_W    = 32,
    parameter int DEV_BASE = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_offset,
    input logic [MAP_W-1:0]  rsp_map,
    input logic              rsp_err
);

    // R7: never ready while a result is held
    p_ready_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R7: result appears one edge after acceptance
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R7: stalled result stays put
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_offset) && $stable(rsp_map) && $stable(rsp_err)));

    // R1: legal results carry the configuration code
    p_cfg_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> (rsp_map[3:1] == 3'b101));

    // R2: type 1 results have no device bits in the map word
    p_t1_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && rsp_map[0]) |-> (rsp_map[MAP_W-1:4] == '0));

    // R5: type 0 selects exactly one device line across offset and map
    p_one_dev_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && !rsp_map[0]) |->
            (($countones(rsp_offset[ADDR_W-1:DEV_BASE]) + $countones(rsp_map[MAP_W-1:4])) == 1));

    // R6: an erroneous result does not disturb offset or map
    p_err_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && rsp_err) |-> ($stable(rsp_offset) && $stable(rsp_map)));

    // R8: reset empties the result stage
    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_err));

endmodule

bind cfgaddr_gen cfgaddr_gen_sva #(
    .ADDR_W   (ADDR_W),
    .MAP_W    (MAP_W),
    .DEV_BASE (DEV_BASE)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_offset (rsp_offset),
    .rsp_map    (rsp_map),
    .rsp_err    (rsp_err)
);

// File: tb/sim_cfgaddr_gen.sv
// Scoreboard bench for cfgaddr_gen.
module sim_cfgaddr_gen;

    localparam int REQ_W  = 10;
    localparam int ADDR_W = 24;
    localparam int MAP_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [REQ_W-1:0]  req_bus = '0;
    logic [REQ_W-1:0]  req_devfn = '0;
    logic [REQ_W-1:0]  req_regoff = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [ADDR_W-1:0] rsp_offset;
    logic [MAP_W-1:0]  rsp_map;
    logic              rsp_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit stall_en = 1'b0;

    logic [ADDR_W-1:0] exp_off_q[$];
    logic [MAP_W-1:0]  exp_map_q[$];
    logic              exp_err_q[$];
    string             tag_q[$];

    logic [ADDR_W-1:0] last_off = '0;
    logic [MAP_W-1:0]  last_map = '0;

    always #5 clk = ~clk;

    cfgaddr_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_bus    (req_bus),
        .req_devfn  (req_devfn),
        .req_regoff (req_regoff),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_offset (rsp_offset),
        .rsp_map    (rsp_map),
        .rsp_err    (rsp_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Consumer ready pattern, changed at the falling edge
    always @(negedge clk) begin
        cyc++;
        rsp_ready <= stall_en ? (cyc % 3 == 2) : 1'b1;
    end

    // Monitor: pops expected items on accepted results, checks stalls (R7)
    logic              prev_stall = 1'b0;
    logic [ADDR_W-1:0] held_off;
    logic [MAP_W-1:0]  held_map;
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (prev_stall) begin
                check(rsp_valid && rsp_offset == held_off && rsp_map == held_map,
                      "R7 hold", {rsp_offset, 8'h0, rsp_map}, {held_off, 8'h0, held_map});
            end
            if (rsp_valid && rsp_ready && exp_off_q.size() > 0) begin
                string t;
                t = tag_q.pop_front();
                check(rsp_err == exp_err_q.pop_front(), {t, " err"}, 64'(rsp_err), 64'(!rsp_err));
                check(rsp_offset == exp_off_q[0], {t, " offset"}, 64'(rsp_offset), 64'(exp_off_q[0]));
                check(rsp_map == exp_map_q[0], {t, " map"}, 64'(rsp_map), 64'(exp_map_q[0]));
                void'(exp_off_q.pop_front());
                void'(exp_map_q.pop_front());
            end
            prev_stall = rsp_valid && !rsp_ready;
            held_off   = rsp_offset;
            held_map   = rsp_map;
        end
    end

    // Driver: computes the expected result from the requirements and sends it
    task automatic send(input int bus, input int devfn, input int regoff, input string tag);
        logic [ADDR_W-1:0] eo;
        logic [MAP_W-1:0]  em;
        logic              ee;
        int slot;
        slot = devfn / 8;
        ee = (bus > 255) || (devfn > 255) || (regoff > 255);
        if (ee) begin
            eo = last_off;
            em = last_map;
        end else if (bus == 0) begin
            eo = ADDR_W'((devfn % 8) << 8) | ADDR_W'(regoff);
            em = 32'hA;
            if (slot > 12) em = em | (32'h1 << (slot - 5));
            else           eo = eo | (ADDR_W'(1) << (slot + 11));
        end else begin
            eo = ADDR_W'((bus << 16) | (devfn << 8) | regoff);
            em = 32'hB;
        end
        if (!ee) begin
            last_off = eo;
            last_map = em;
        end
        exp_off_q.push_back(eo);
        exp_map_q.push_back(em);
        exp_err_q.push_back(ee);
        tag_q.push_back(tag);
        @(negedge clk);
        req_bus    = REQ_W'(bus);
        req_devfn  = REQ_W'(devfn);
        req_regoff = REQ_W'(regoff);
        req_valid  = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && !req_ready, "R7 latency", 64'(rsp_valid), 64'd1);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(!rsp_valid && req_ready && !rsp_err, "R8 flags", {rsp_valid, req_ready, rsp_err}, 3'b010);
        check(rsp_offset == '0 && rsp_map == '0, "R8 data", 64'(rsp_offset), 64'd0);
        rst_n = 1'b1;

        send(0, 0,           0,   "R4 slot0");
        send(0, 5*8 + 3,     8'h3C, "R3 slot5 fn3");
        send(0, 12*8 + 7,    8'hFF, "R4 slot12 boundary");
        send(0, 13*8 + 1,    8'h10, "R5 slot13 boundary");
        send(0, 20*8 + 2,    8'h04, "R5 slot20");
        send(0, 31*8 + 7,    8'hFC, "R5 slot31");
        send(1, 8'h2A,       8'h40, "R2 bus1");
        send(255, 8'hFF,     8'hFF, "R2 bus255");
        send(0, 9*8,         256,   "R6 regoff256");
        send(300, 8'h11,     0,     "R6 bus300");
        send(0, 511,         0,     "R6 devfn511");
        send(0, 2*8 + 6,     8'h08, "R1 after error");
        stall_en = 1'b1;
        send(7, 8'h81,       8'h24, "R2 stalled");
        send(0, 14*8 + 5,    8'h00, "R5 stalled");
        send(0, 3*8 + 1,     8'hA8, "R4 stalled");
        send(1023, 0,        0,     "R6 stalled");
        send(128, 8'h00,     8'h00, "R2 stalled zero devfn");
        while (exp_off_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule